// File: doc/BRIEF.md
# USB OTG Wrapper Register Bridge

This block sits between a host register port and the register port of a USB on-the-go core. It splits a 4 KB window into three parts. Offsets below 0x200 go straight to the core. Offsets 0x200 to 0x3FF are folded onto a small range of core registers. Offsets from 0x400 upward reach a handful of wrapper registers that the bridge holds itself.

The wrapper registers cover:
- an identification value and a status value, both fixed;
- a configuration word whose bit 1 requests a soft reset;
- a two-bit interface choice;
- an unsupported simulation-mode enable;
- a standby-force bit that drives the standby request output.

Every read answers exactly one cycle after its request. A core read takes its data from the core in that cycle, and a wrapper read takes it from a register filled at the request edge.

Top module: `usbotg_wrap_bridge`

## Requirements
- R1: A request at offset below 0x200 drives the core port in the same cycle with the unchanged offset, the same write flag, write data and access size (size code 0 byte, 1 halfword, 2 word).
- R2: A request at offset 0x200 to 0x3FF drives the core port in the same cycle at core offset 0x20 + ((offset >> 3) & 0x3C).
- R3: A request at offset 0x400 or above never raises the core request.
- R4: After reset the configuration word (0x404) reads 0, interface choice (0x40C) reads 1, simulation enable (0x410) reads 0, standby-force (0x414) reads 1, the standby output is 1, and the error, core-reset and bad-address outputs are 0.
- R5: The identification register (0x400) reads 0x33 and the status register (0x408) reads 1; writes to either change nothing.
- R6: A write to 0x40C keeps only bits [1:0]; a write to 0x414 keeps only bit 0, and the standby output equals that bit from the cycle after the write.
- R7: A write to 0x404 with bit 1 clear stores the written value ANDed with 0x301F.
- R8: A write to 0x404 with bit 1 set returns every wrapper register and the error flag to its reset value, pulses the core-reset output high for exactly the cycle after the write, and then stores the written value ANDed with 0x301F.
- R9: A write to 0x410 sets the error output from the next cycle; it stays set until a soft reset or reset, and 0x410 still reads 0.
- R10: A read at an unmapped wrapper offset (0x400 or above, not one of the six word offsets) returns 0 and raises the bad-address output in its response cycle only; a write there changes no register.
- R11: The read-valid output is high exactly in the cycle after a read request; for core offsets the read data in that cycle is the core's read data.
- R12: The access size is ignored for wrapper registers. A wrapper write takes the low bits of the write data whatever the size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access request, one cycle per access |
| h_we | input | 1 | Host write flag |
| h_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| h_addr | input | 12 | Byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read response valid |
| h_rdata | output | 32 | Read response data |
| c_req | output | 1 | Core register access request |
| c_we | output | 1 | Core write flag |
| c_size | output | 2 | Core access size code |
| c_addr | output | 9 | Core register offset |
| c_wdata | output | 32 | Core write data |
| c_rdata | input | 32 | Core read data, valid the cycle after a core read |
| core_rst | output | 1 | One-cycle core reset pulse |
| stdby | output | 1 | Standby request |
| sim_err | output | 1 | Sticky unsupported-mode error |
| bad_addr | output | 1 | Unmapped wrapper read flag |

## Verification
The core port fields are combinational, so they are sampled in the request cycle, shortly after the inputs are driven and before the capturing edge. Read data, read-valid and the bad-address flag each pass through one register. They are sampled at the falling edge after the capturing edge.

Register updates land at the request edge, so the standby output and the error flag are checked at that same falling edge. The core-reset pulse is checked there as well, and again one cycle later to confirm it has fallen.

// File: rtl/usbotg_wrap_pkg.sv
package usbotg_wrap_pkg;

    typedef enum logic [1:0] {
        RGN_DIRECT,
        RGN_FOLD,
        RGN_LOCAL
    } region_e;

    typedef enum logic [2:0] {
        LR_ID,
        LR_CFG,
        LR_STAT,
        LR_IFSEL,
        LR_SIMEN,
        LR_STBY,
        LR_NONE
    } lreg_e;

    localparam logic [11:0] OFS_FOLD_LO  = 12'h200;
    localparam logic [11:0] OFS_LOCAL_LO = 12'h400;
    localparam logic [11:0] OFS_ID       = 12'h400;
    localparam logic [11:0] OFS_CFG      = 12'h404;
    localparam logic [11:0] OFS_STAT     = 12'h408;
    localparam logic [11:0] OFS_IFSEL    = 12'h40C;
    localparam logic [11:0] OFS_SIMEN    = 12'h410;
    localparam logic [11:0] OFS_STBY     = 12'h414;

    localparam logic [7:0]  ID_VALUE     = 8'h33;
    localparam logic [15:0] CFG_KEEP     = 16'h301F;
    localparam logic [1:0]  IFSEL_INIT   = 2'b01;
    localparam int          CFG_SRST_BIT = 1;

    // Folded core offset: base 0x20 plus offset bits [8:5] placed at [5:2]
    function automatic logic [8:0] fold_ofs(input logic [11:0] ofs);
        return 9'h020 + {3'b000, ofs[8:5], 2'b00};
    endfunction

endpackage

// File: rtl/usbotg_wrap_decode.sv
module usbotg_wrap_decode
    import usbotg_wrap_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output lreg_e             lsel
);
    logic [11:0] ofs;
    assign ofs = 12'(addr);

    always_comb begin
        if (ofs >= OFS_LOCAL_LO)     region = RGN_LOCAL;
        else if (ofs >= OFS_FOLD_LO) region = RGN_FOLD;
        else                         region = RGN_DIRECT;

        unique case (ofs)
            OFS_ID:    lsel = LR_ID;
            OFS_CFG:   lsel = LR_CFG;
            OFS_STAT:  lsel = LR_STAT;
            OFS_IFSEL: lsel = LR_IFSEL;
            OFS_SIMEN: lsel = LR_SIMEN;
            OFS_STBY:  lsel = LR_STBY;
            default:   lsel = LR_NONE;
        endcase
    end
endmodule

// File: rtl/usbotg_wrap_regs.sv
module usbotg_wrap_regs
    import usbotg_wrap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  lreg_e             sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q,
    output logic              bad_q,
    output logic              stby_q,
    output logic              core_rst_q,
    output logic              err_q
);
    logic [15:0]       cfg_q;
    logic [1:0]        ifsel_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            LR_ID:    rd_mux = DATA_W'(ID_VALUE);
            LR_CFG:   rd_mux = DATA_W'(cfg_q);
            LR_STAT:  rd_mux = DATA_W'(1);
            LR_IFSEL: rd_mux = DATA_W'(ifsel_q);
            LR_SIMEN: rd_mux = '0;
            LR_STBY:  rd_mux = DATA_W'(stby_q);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            ifsel_q    <= IFSEL_INIT;
            stby_q     <= 1'b1;
            err_q      <= 1'b0;
            core_rst_q <= 1'b0;
            bad_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            core_rst_q <= 1'b0;
            bad_q      <= 1'b0;
            if (rd_en) begin
                rdata_q <= rd_mux;
                bad_q   <= (sel == LR_NONE);
            end
            if (wr_en) begin
                unique case (sel)
                    LR_CFG: begin
                        if (wdata[CFG_SRST_BIT]) begin
                            ifsel_q    <= IFSEL_INIT;
                            stby_q     <= 1'b1;
                            err_q      <= 1'b0;
                            core_rst_q <= 1'b1;
                        end
                        cfg_q <= wdata[15:0] & CFG_KEEP;
                    end
                    LR_IFSEL: ifsel_q <= wdata[1:0];
                    LR_SIMEN: err_q   <= 1'b1;
                    LR_STBY:  stby_q  <= wdata[0];
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/usbotg_wrap_bridge.sv
module usbotg_wrap_bridge
    import usbotg_wrap_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int CORE_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_req,
    input  logic               h_we,
    input  logic [1:0]         h_size,
    input  logic [ADDR_W-1:0]  h_addr,
    input  logic [DATA_W-1:0]  h_wdata,
    output logic               h_rvalid,
    output logic [DATA_W-1:0]  h_rdata,
    output logic               c_req,
    output logic               c_we,
    output logic [1:0]         c_size,
    output logic [CORE_AW-1:0] c_addr,
    output logic [DATA_W-1:0]  c_wdata,
    input  logic [DATA_W-1:0]  c_rdata,
    output logic               core_rst,
    output logic               stdby,
    output logic               sim_err,
    output logic               bad_addr
);
    region_e           region;
    lreg_e             lsel;
    logic              loc_acc;
    logic [DATA_W-1:0] loc_rdata;
    logic              rsp_valid_q;
    logic              rsp_core_q;

    usbotg_wrap_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (h_addr),
        .region (region),
        .lsel   (lsel)
    );

    assign loc_acc = h_req && (region == RGN_LOCAL);

    usbotg_wrap_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (loc_acc && h_we),
        .rd_en      (loc_acc && !h_we),
        .sel        (lsel),
        .wdata      (h_wdata),
        .rdata_q    (loc_rdata),
        .bad_q      (bad_addr),
        .stby_q     (stdby),
        .core_rst_q (core_rst),
        .err_q      (sim_err)
    );

    always_comb begin
        c_req   = h_req && (region != RGN_LOCAL);
        c_we    = h_we;
        c_size  = h_size;
        c_wdata = h_wdata;
        if (region == RGN_FOLD) c_addr = CORE_AW'(fold_ofs(12'(h_addr)));
        else                    c_addr = CORE_AW'(h_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_core_q  <= 1'b0;
        end else begin
            rsp_valid_q <= h_req && !h_we;
            rsp_core_q  <= h_req && !h_we && (region != RGN_LOCAL);
        end
    end

    assign h_rvalid = rsp_valid_q;
    assign h_rdata  = rsp_core_q ? c_rdata : loc_rdata;
endmodule

// File: rtl/usbotg_wrap_chk.sv
module usbotg_wrap_chk #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int CORE_AW = 9
) (
    input logic               clk,
    input logic               rst,
    input logic               h_req,
    input logic               h_we,
    input logic [1:0]         h_size,
    input logic [ADDR_W-1:0]  h_addr,
    input logic [DATA_W-1:0]  h_wdata,
    input logic               h_rvalid,
    input logic               c_req,
    input logic [1:0]         c_size,
    input logic [CORE_AW-1:0] c_addr,
    input logic               core_rst,
    input logic               stdby,
    input logic               sim_err,
    input logic               bad_addr
);
    logic is_srst_wr;
    assign is_srst_wr = h_req && h_we && (h_addr == ADDR_W'(12'h404)) && h_wdata[1];

    a_r1_direct: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_addr < ADDR_W'(12'h200)) |->
            (c_req && c_addr == CORE_AW'(h_addr) && c_size == h_size));

    a_r2_fold_range: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_addr >= ADDR_W'(12'h200) && h_addr < ADDR_W'(12'h400)) |->
            (c_req && c_addr >= CORE_AW'(9'h020) && c_addr <= CORE_AW'(9'h05C)));

    a_r3_no_core: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_addr >= ADDR_W'(12'h400)) |-> !c_req);

    a_r6_stdby: assert property (@(posedge clk) disable iff (rst)
        (h_req && h_we && h_addr == ADDR_W'(12'h414)) |=> (stdby == $past(h_wdata[0])));

    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        is_srst_wr |=> (core_rst && stdby && !sim_err));

    a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (core_rst && !is_srst_wr) |=> !core_rst);

    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (sim_err && !is_srst_wr) |=> sim_err);

    a_r10_bad_valid: assert property (@(posedge clk) disable iff (rst)
        bad_addr |-> h_rvalid);

    a_r11_rvalid: assert property (@(posedge clk) disable iff (rst)
        (h_req && !h_we) |=> h_rvalid);
endmodule

bind usbotg_wrap_bridge usbotg_wrap_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_AW(CORE_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .h_req    (h_req),
    .h_we     (h_we),
    .h_size   (h_size),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .h_rvalid (h_rvalid),
    .c_req    (c_req),
    .c_size   (c_size),
    .c_addr   (c_addr),
    .core_rst (core_rst),
    .stdby    (stdby),
    .sim_err  (sim_err),
    .bad_addr (bad_addr)
);

// File: tb/usbotg_wrap_bridge_tb.sv
module usbotg_wrap_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [1:0]  h_size = 2'd2;
    logic [11:0] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_rvalid;
    logic [31:0] h_rdata;
    logic        c_req, c_we;
    logic [1:0]  c_size;
    logic [8:0]  c_addr;
    logic [31:0] c_wdata;
    logic [31:0] c_rdata = '0;
    logic        core_rst, stdby, sim_err, bad_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // sampled results of the last access
    logic        s_creq, s_cwe, s_rvalid, s_bad, s_crst;
    logic [1:0]  s_csize;
    logic [8:0]  s_caddr;
    logic [31:0] s_cwdata, s_rdata;

    always #10 clk = ~clk;

    usbotg_wrap_bridge u_dut (
        .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_size(h_size),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .c_req(c_req), .c_we(c_we), .c_size(c_size), .c_addr(c_addr),
        .c_wdata(c_wdata), .c_rdata(c_rdata), .core_rst(core_rst), .stdby(stdby),
        .sim_err(sim_err), .bad_addr(bad_addr)
    );

    // simple core model: read data one cycle after a core read
    always @(posedge clk)
        if (c_req && !c_we) c_rdata <= 32'hC0DE0000 | {23'd0, c_addr};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit we, input logic [1:0] sz, input logic [11:0] a,
                       input logic [31:0] wd);
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
        #1;
        s_creq = c_req; s_cwe = c_we; s_csize = c_size; s_caddr = c_addr; s_cwdata = c_wdata;
        @(negedge clk);
        s_rvalid = h_rvalid; s_rdata = h_rdata; s_bad = bad_addr; s_crst = core_rst;
        h_req = 1'b0; h_we = 1'b0;
    endtask

    function automatic logic [8:0] exp_core(input logic [11:0] a);
        if (a < 12'h200) return a[8:0];
        return 9'h20 + 9'(((a >> 3) & 12'h03C));
    endfunction

    task automatic rd_local(input logic [11:0] a, input logic [31:0] exp, input string req);
        acc(1'b0, 2'd2, a, 32'h0);
        chk(s_rvalid && s_rdata == exp && !s_creq, req, s_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R4 reset state at ports
        chk(stdby == 1'b1, "R4 stdby", 32'(stdby), 1);
        chk(!sim_err && !core_rst && !bad_addr && !h_rvalid, "R4 flags",
            {28'd0, sim_err, core_rst, bad_addr, h_rvalid}, 0);
        rd_local(12'h404, 32'h0, "R4 cfg");
        rd_local(12'h40C, 32'h1, "R4 ifsel");
        rd_local(12'h410, 32'h0, "R4 simen");
        rd_local(12'h414, 32'h1, "R4 stby");
        rd_local(12'h400, 32'h33, "R5 id");
        rd_local(12'h408, 32'h1, "R5 stat");

        // R1 R2 R11: sweep every core-mapped offset with rotating sizes
        for (int a = 0; a < 12'h400; a++) begin
            logic [1:0] sz;
            logic [8:0] ea;
            sz = 2'(a % 3);
            ea = exp_core(12'(a));
            acc(1'b0, sz, 12'(a), 32'h0);
            if (a < 12'h200)
                chk(s_creq && !s_cwe && s_caddr == ea && s_csize == sz, "R1 direct", 32'(s_caddr), 32'(ea));
            else
                chk(s_creq && s_caddr == ea && s_csize == sz, "R2 fold", 32'(s_caddr), 32'(ea));
            chk(s_rvalid && s_rdata == (32'hC0DE0000 | 32'(ea)) && !s_bad, "R11 core read",
                s_rdata, 32'hC0DE0000 | 32'(ea));
        end
        // R1 write forwarding
        acc(1'b1, 2'd1, 12'h1A6, 32'h1234ABCD);
        chk(s_creq && s_cwe && s_caddr == 9'h1A6 && s_cwdata == 32'h1234ABCD && s_csize == 2'd1,
            "R1 write", s_cwdata, 32'h1234ABCD);
        chk(!s_rvalid, "R11 no rvalid on write", 32'(s_rvalid), 0);
        acc(1'b1, 2'd0, 12'h3F8, 32'h55);
        chk(s_creq && s_cwe && s_caddr == 9'h05C, "R2 write fold", 32'(s_caddr), 32'h5C);

        // R3 R10: sweep wrapper space reads
        for (int a = 12'h400; a < 12'h500; a++) begin
            logic [31:0] ev;
            bit mapped;
            mapped = 1'b1;
            case (a)
                12'h400: ev = 32'h33;
                12'h404: ev = 32'h0;
                12'h408: ev = 32'h1;
                12'h40C: ev = 32'h1;
                12'h410: ev = 32'h0;
                12'h414: ev = 32'h1;
                default: begin ev = 32'h0; mapped = 1'b0; end
            endcase
            acc(1'b0, 2'(a % 3), 12'(a), 32'h0);
            chk(!s_creq, "R3 no core req", 32'(s_creq), 0);
            chk(s_rvalid && s_rdata == ev && s_bad == !mapped, "R10 local read",
                {s_rdata[30:0], s_bad}, {ev[30:0], !mapped});
        end
        acc(1'b0, 2'd2, 12'hFFC, 32'h0);
        chk(s_bad && s_rdata == 0 && !s_creq, "R10 top offset", 32'(s_bad), 1);
        @(negedge clk);
        chk(!bad_addr, "R10 bad one cycle", 32'(bad_addr), 0);

        // R6 R12
        acc(1'b1, 2'd0, 12'h40C, 32'hFFFFFFFE);
        rd_local(12'h40C, 32'h2, "R6 ifsel");
        acc(1'b1, 2'd1, 12'h414, 32'hFFFFFFFE);
        chk(stdby == 1'b0, "R6 stdby low", 32'(stdby), 0);
        rd_local(12'h414, 32'h0, "R6 stby read");
        acc(1'b1, 2'd2, 12'h414, 32'h00000003);
        chk(stdby == 1'b1, "R6 stdby high", 32'(stdby), 1);
        acc(1'b1, 2'd0, 12'h40C, 32'h00000003);
        rd_local(12'h40C, 32'h3, "R12 byte write ifsel");

        // R5 writes to read-only ignored
        acc(1'b1, 2'd2, 12'h400, 32'hFFFFFFFF);
        acc(1'b1, 2'd2, 12'h408, 32'h0);
        rd_local(12'h400, 32'h33, "R5 id after write");
        rd_local(12'h408, 32'h1, "R5 stat after write");

        // R7
        acc(1'b1, 2'd2, 12'h404, 32'hFFFFFFFD);
        chk(!s_crst, "R7 no core reset", 32'(s_crst), 0);
        rd_local(12'h404, 32'h301D, "R7 cfg mask");

        // R10 unmapped writes leave registers alone
        acc(1'b1, 2'd2, 12'h418, 32'hFFFFFFFF);
        acc(1'b1, 2'd2, 12'h402, 32'h0);
        rd_local(12'h404, 32'h301D, "R10 cfg kept");
        rd_local(12'h40C, 32'h3, "R10 ifsel kept");
        chk(stdby == 1'b1 && !sim_err, "R10 flags kept", {30'd0, stdby, sim_err}, 2);

        // R9
        acc(1'b1, 2'd2, 12'h410, 32'h1);
        chk(sim_err == 1'b1, "R9 err set", 32'(sim_err), 1);
        rd_local(12'h410, 32'h0, "R9 simen reads 0");
        acc(1'b1, 2'd2, 12'h404, 32'h0);
        acc(1'b1, 2'd2, 12'h414, 32'h0);
        chk(sim_err == 1'b1, "R9 err sticky", 32'(sim_err), 1);

        // R8 soft reset
        acc(1'b1, 2'd2, 12'h40C, 32'h2);
        acc(1'b1, 2'd2, 12'h404, 32'h0000FFFF);
        chk(s_crst == 1'b1, "R8 core reset pulse", 32'(s_crst), 1);
        chk(stdby == 1'b1 && !sim_err, "R8 flags reset", {30'd0, stdby, sim_err}, 2);
        @(negedge clk);
        chk(!core_rst, "R8 pulse one cycle", 32'(core_rst), 0);
        rd_local(12'h404, 32'h301F, "R8 cfg stored");
        rd_local(12'h40C, 32'h1, "R8 ifsel reset");
        rd_local(12'h414, 32'h1, "R8 stby reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule